// File: doc/BRIEF.md
# Pseudorandom Spread-Spectrum Clock Generator

This block makes a dithered clock for the external synchronisation input of a switching regulator. A fixed reference clock steps a 16-stage maximal-length linear feedback shift register, one chip per reference cycle. Bit 15 of the register is the raw pseudorandom bit. It also steers a single output flip-flop. On every reference edge where the bit is 1 the flip-flop toggles, and where it is 0 the flip-flop holds. The result is a clock with an irregular period, so the regulator's switching energy is spread over a band instead of sitting in one spectral line.

A synchronous clear loads a fixed nonzero seed. An enable input chooses between two modes. In spread mode the register advances and the output is dithered. In fixed mode the register is frozen and the output toggles on every reference edge, which gives a steady comparison tone. Both outputs come straight from flip-flops, so no glitch can reach the regulator. If the register ever holds all zeros, it reseeds on the next edge.

Top module: `ssc_spread_clkgen`

## Requirements
- R1: At a rising edge with `rst` high, the register is loaded with seed 16'h0001 and `spread_clk` is cleared to 0. This gives `prn_bit` = 0 and `spread_clk` = 0 after that edge, whatever the value of `en`.
- R2: At a rising edge with `en` high and `rst` low, the register shifts one place toward bit 15. Bit 0 takes the XOR of bits 15, 14, 12 and 3 (taps 16, 15, 13, 4). `prn_bit` always equals register bit 15.
- R3: With `en` held high, the register state repeats with a period of exactly 65535 edges, and no state recurs earlier.
- R4: At a rising edge with `en` high and `rst` low, `spread_clk` toggles if `prn_bit` was 1 before the edge and keeps its value if `prn_bit` was 0.
- R5: At a rising edge with `en` low and `rst` low, the register holds its state, so `prn_bit` does not change.
- R6: At a rising edge with `en` low and `rst` low, `spread_clk` toggles, which gives a plain divide-by-two of the reference.
- R7: When `en` goes high again after a hold, the sequence continues from the held state, with no chip lost or repeated.
- R8: `spread_clk` and `prn_bit` change only at rising reference edges and stay constant between them.
- R9: Over one full 65535-edge period in spread mode, `spread_clk` toggles exactly 32768 times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; every register uses its rising edge |
| rst | input | 1 | Synchronous active-high clear; loads the seed |
| en | input | 1 | 1 = spread mode, 0 = fixed divide-by-two with the register frozen |
| spread_clk | output | 1 | Registered dithered clock for the regulator |
| prn_bit | output | 1 | Raw pseudorandom bit (register bit 15) |

## Verification
The bench runs the generator for a whole period plus a 16-chip overlap and compares every chip with an independent polynomial model. A wrong tap or a wrong shift direction would show as an early divergence, and the sequence would fail to return to its starting window at 65535. The bench counts output toggles over that period. An output stage that toggled on 0 instead of 1, or that missed the XOR feedback, would give a count different from 32768. Fixed mode is checked for a frozen bit and a steady alternation, and resume is checked for a lost chip. Clear is applied with enable still high, to catch a clear that enable overrides. The outputs are also sampled twice within each half period, to catch any combinational path after the flip-flops.

// File: rtl/ssc_pkg.sv
package ssc_pkg;
  // register length and polynomial (x^16+x^15+x^13+x^4+1)
  localparam int unsigned LFSR_W = 16;
  localparam logic [LFSR_W-1:0] LFSR_TAPS = 16'hD008; // bits 15,14,12,3
  localparam logic [LFSR_W-1:0] LFSR_SEED = 16'h0001;
endpackage

// File: rtl/ssc_lfsr.sv
module ssc_lfsr #(
  parameter int unsigned        W        = ssc_pkg::LFSR_W,
  parameter logic [W-1:0]       TAP_MASK = ssc_pkg::LFSR_TAPS,
  parameter logic [W-1:0]       SEED     = ssc_pkg::LFSR_SEED
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         adv,
  output logic [W-1:0] state,
  output logic         out_bit
);
  localparam int unsigned MSB = W - 1;

  logic [W-1:0] state_q;
  logic [W:0]   fb_chain;

  // feedback XOR built tap by tap
  assign fb_chain[0] = 1'b0;
  for (genvar g = 0; g < W; g++) begin : g_tap
    if (TAP_MASK[g]) begin : g_on
      assign fb_chain[g+1] = fb_chain[g] ^ state_q[g];
    end else begin : g_off
      assign fb_chain[g+1] = fb_chain[g];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SEED;
    end else if (state_q == '0) begin
      state_q <= SEED;                       // lock-up guard
    end else if (adv) begin
      state_q <= {state_q[MSB-1:0], fb_chain[W]};
    end
  end

  assign state   = state_q;
  assign out_bit = state_q[MSB];
endmodule

// File: rtl/ssc_toggle_stage.sv
module ssc_toggle_stage (
  input  logic clk,
  input  logic rst,
  input  logic spread_en,
  input  logic ctrl,
  output logic q
);
  logic q_r;
  logic flip;

  // spread mode: toggle on ctrl; fixed mode: toggle every edge
  assign flip = spread_en ? ctrl : 1'b1;

  always_ff @(posedge clk) begin
    if (rst) q_r <= 1'b0;
    else     q_r <= q_r ^ flip;
  end

  assign q = q_r;
endmodule

// File: rtl/ssc_spread_clkgen.sv
module ssc_spread_clkgen #(
  parameter int unsigned  W        = ssc_pkg::LFSR_W,
  parameter logic [W-1:0] TAP_MASK = ssc_pkg::LFSR_TAPS,
  parameter logic [W-1:0] SEED     = ssc_pkg::LFSR_SEED
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic spread_clk,
  output logic prn_bit
);
  logic [W-1:0] state_w;
  logic         chip;

  ssc_lfsr #(.W(W), .TAP_MASK(TAP_MASK), .SEED(SEED)) u_lfsr (
    .clk(clk), .rst(rst), .adv(en), .state(state_w), .out_bit(chip)
  );

  ssc_toggle_stage u_out (
    .clk(clk), .rst(rst), .spread_en(en), .ctrl(chip), .q(spread_clk)
  );

  assign prn_bit = chip;
endmodule

// File: rtl/ssc_spread_clkgen_chk.sv
module ssc_spread_clkgen_chk #(
  parameter int unsigned W = ssc_pkg::LFSR_W
) (
  input logic         clk,
  input logic         rst,
  input logic         en,
  input logic         spread_clk,
  input logic         prn_bit,
  input logic [W-1:0] state
);
  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (spread_clk == 1'b0 && prn_bit == 1'b0));

  // R2
  shift_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(en) && !$past(rst)) |-> state[W-1:1] == $past(state[W-2:0]));

  // R4
  spread_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(en) && !$past(rst)) |-> spread_clk == ($past(spread_clk) ^ $past(prn_bit)));

  // R5
  hold_state_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(en) && !$past(rst)) |-> $stable(state));

  // R6
  fixed_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(en) && !$past(rst)) |-> spread_clk != $past(spread_clk));

  // R3
  nonzero_state_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> state != '0);
endmodule

bind ssc_spread_clkgen ssc_spread_clkgen_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .en(en), .spread_clk(spread_clk),
  .prn_bit(prn_bit), .state(state_w)
);

// File: tb/test_ssc_spread_clkgen.sv
module test_ssc_spread_clkgen;
  localparam int PERIOD = 65535;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b0;
  logic spread_clk, prn_bit;

  int n_chk = 0;
  int n_err = 0;

  logic [15:0] m_state;
  logic        m_sc;

  always #5 clk = ~clk;

  ssc_spread_clkgen i_ssc_spread_clkgen (
    .clk(clk), .rst(rst), .en(en), .spread_clk(spread_clk), .prn_bit(prn_bit)
  );

  function automatic logic [15:0] poly_next(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[14] ^ s[12] ^ s[3]};
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // outputs are read at negedge; the model is advanced for the following posedge
  task automatic model_step();
    if (en) begin
      m_sc    = m_sc ^ m_state[15];
      m_state = poly_next(m_state);
    end else begin
      m_sc = ~m_sc;
    end
  endtask

  task automatic t_reset();
    rst = 1'b1; en = 1'b1;           // R1: clear wins over enable
    @(negedge clk); @(negedge clk);
    chk(prn_bit == 1'b0, "R1 prn_bit after clear", prn_bit, 0);
    chk(spread_clk == 1'b0, "R1 spread_clk after clear", spread_clk, 0);
    rst = 1'b0;
    m_state = 16'h0001; m_sc = 1'b0;
  endtask

  task automatic t_full_period();
    int  bad_bit = 0, bad_sc = 0, toggles = 0, ret = 0;
    logic [15:0] first_win = '0, wrap_win = '0, s;
    logic prev_sc = 1'b0;
    en = 1'b1;
    for (int i = 0; i <= PERIOD + 15; i++) begin
      if (prn_bit !== m_state[15]) bad_bit++;
      if (spread_clk !== m_sc) bad_sc++;
      if (i > 0 && i <= PERIOD && spread_clk != prev_sc) toggles++;
      if (i < 16) first_win = {first_win[14:0], prn_bit};
      if (i >= PERIOD) wrap_win = {wrap_win[14:0], prn_bit};
      prev_sc = spread_clk;
      model_step();
      @(negedge clk);
    end
    chk(bad_bit == 0, "R2 prn_bit vs polynomial model", bad_bit, 0);
    chk(bad_sc == 0, "R4 spread_clk toggle rule", bad_sc, 0);
    chk(toggles == 32768, "R9 toggles per period", toggles, 32768);
    chk(wrap_win == first_win, "R3 window repeats after 65535", wrap_win, first_win);
    s = 16'h0001;
    for (int k = 1; k <= PERIOD; k++) begin
      s = poly_next(s);
      if (s == 16'h0001 && ret == 0) ret = k;
    end
    chk(ret == PERIOD, "R3 first return of seed state", ret, PERIOD);
  endtask

  task automatic t_hold();
    logic p0;
    int   bad_hold = 0, bad_tog = 0;
    logic prev;
    en = 1'b0;
    p0 = prn_bit; prev = spread_clk;
    for (int i = 0; i < 20; i++) begin
      model_step();
      @(negedge clk);
      if (prn_bit != p0) bad_hold++;
      if (spread_clk == prev) bad_tog++;
      prev = spread_clk;
    end
    chk(bad_hold == 0, "R5 prn_bit frozen while disabled", bad_hold, 0);
    chk(bad_tog == 0, "R6 divide-by-two while disabled", bad_tog, 0);
    chk(spread_clk == m_sc, "R6 fixed-mode phase", spread_clk, m_sc);
  endtask

  task automatic t_resume();
    int bad = 0;
    en = 1'b1;
    for (int i = 0; i < 40; i++) begin
      if (prn_bit !== m_state[15] || spread_clk !== m_sc) bad++;
      model_step();
      @(negedge clk);
    end
    chk(bad == 0, "R7 sequence resumes from held state", bad, 0);
  endtask

  task automatic t_glitch();
    int bad = 0;
    logic a, b;
    for (int i = 0; i < 64; i++) begin
      en = (i % 16) < 12;
      a = spread_clk; b = prn_bit;
      #4;
      if (spread_clk != a || prn_bit != b) bad++;
      @(posedge clk); #1;
      a = spread_clk; b = prn_bit;
      #3;
      if (spread_clk != a || prn_bit != b) bad++;
      @(negedge clk);
    end
    chk(bad == 0, "R8 outputs stable between rising edges", bad, 0);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    #1_900_000;
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin
    m_state = 16'h0001; m_sc = 1'b0;
    @(negedge clk);
    t_reset();
    t_full_period();
    t_hold();
    t_resume();
    t_glitch();
    t_reset();                       // R1 again, from mid-sequence
    @(negedge clk);
    chk(prn_bit == 1'b0, "R2 first chip after reseed", prn_bit, 0);
    finish_run();
  end
endmodule